// File: doc/BRIEF.md
# Reset Cause Capture Controller

This block merges six independent reset request lines into one internal system reset and keeps a record of which line started the most recent reset. The request lines are a power-up detect, an external reset pin, a clock-loss detect, a watchdog timeout, a processor halt that signals a double bus fault, and a one-cycle strobe raised when software executes a reset instruction. All inputs are synchronous to `clk`.

A reset event begins on the first cycle in which any enabled request is active while no reset is in progress. In that cycle the highest-priority active request is written into a one-hot cause register, replacing whatever was there before. The system reset output stays high while any request is active and for a fixed stretch of cycles after the last one drops. Requests that arrive during a reset extend it but do not rewrite the cause. Power-up is the only exception: it always rewrites the cause and also returns the control register to its default.

A small register port gives read access to the cause register and read/write access to a control register. That control register holds the enable for the halt path. When the enable is cleared, a processor halt is ignored.

Top module: `rst_cause_ctl`

## Requirements
- R1: The cause register (read address 0) is one-hot over bits [5:0], and bits above 5 read 0. Bit 0 means power-up, bit 1 external pin, bit 2 clock loss, bit 3 watchdog, bit 4 double bus fault (halt), and bit 5 software reset instruction.
- R2: When several requests start a reset in the same cycle, the cause is taken from the highest-priority one. The order from highest to lowest is power-up, external, clock loss, watchdog, halt, software.
- R3: A request that becomes active while `sys_rst` is already high does not change the cause register. It does extend the reset. Power-up is the exception and always sets the cause to bit 0.
- R4: When the halt enable is 1, `cpu_halt` starts a reset and records cause bit 4.
- R5: When the halt enable is 0, `cpu_halt` leaves `sys_rst` low and leaves the cause register unchanged.
- R6: A power-up request sets the cause to 0x01 and the halt enable to 1. Every other reset source leaves the control register unchanged.
- R7: `sys_rst` is high in every cycle in which an enabled request is active. It then stays high for exactly 16 more cycles after the last such cycle.
- R8: Writes to address 0 have no effect on the cause register.
- R9: The control register is at address 1, and bit 0 of it is the halt enable. It is written through `wr_en`/`wr_addr`/`wr_data`, and the write takes effect on the next edge. The other bits of address 1, and every other address, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on | input | 1 | Power-up detect request, also resets the block |
| ext_rst | input | 1 | External reset pin request |
| clk_lost | input | 1 | Clock-loss detect request |
| wdog_exp | input | 1 | Watchdog timeout request |
| cpu_halt | input | 1 | Processor halt (double bus fault) |
| sw_rst_stb | input | 1 | Software reset instruction strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sys_rst | output | 1 | Stretched internal system reset |

## Verification
Two things can land in the same cycle: the start of a reset from one source, and a second request or a control-register write. The bench provokes this in two ways. Directed cases raise several requests together, and others raise a new request during the 16-cycle tail of a reset. A sparse random stream also mixes requests with writes to both addresses. Every cycle is judged against a bench model built from the priority, capture and stretch rules, and explicit constants are checked for the cause and the enable in each corner case.

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl #(
  parameter int STRETCH = 16,
  parameter int DW      = 8,
  parameter int AW      = 2
) (
  input  logic          clk,
  input  logic          pwr_on,
  input  logic          ext_rst,
  input  logic          clk_lost,
  input  logic          wdog_exp,
  input  logic          cpu_halt,
  input  logic          sw_rst_stb,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sys_rst
);
  localparam int NC = 6;
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [AW-1:0] A_CAUSE = AW'(0);
  localparam logic [AW-1:0] A_CTRL  = AW'(1);

  logic [NC-1:0] cause_q;
  logic          halt_en_q;
  logic [CW-1:0] cnt_q;
  logic [NC-1:0] req, pick;
  logic          busy, any_req;
  logic          unused_wr_hi;

  assign req     = {sw_rst_stb, cpu_halt & halt_en_q, wdog_exp, clk_lost, ext_rst, pwr_on};
  assign pick    = req & (~req + 1'b1);
  assign any_req = |req;
  assign busy    = cnt_q != '0;
  assign sys_rst = any_req | busy;
  assign unused_wr_hi = ^wr_data[DW-1:1];

  always_ff @(posedge clk) begin
    if (pwr_on) begin
      cause_q   <= NC'(1);
      halt_en_q <= 1'b1;
      cnt_q     <= CW'(STRETCH);
    end else begin
      if (any_req)   cnt_q <= CW'(STRETCH);
      else if (busy) cnt_q <= cnt_q - 1'b1;
      if (any_req && !busy) cause_q <= pick;
      if (wr_en && wr_addr == A_CTRL) halt_en_q <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CAUSE: rd_data[NC-1:0] = cause_q;
      A_CTRL:  rd_data[0]      = halt_en_q;
      default: rd_data         = '0;
    endcase
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (pwr_on)
    $countones(cause_q) == 1);
  a_r2_ext_first: assert property (@(posedge clk) disable iff (pwr_on)
    (ext_rst && !busy) |=> cause_q == NC'(2));
  a_r3_hold: assert property (@(posedge clk) disable iff (pwr_on)
    (busy && !pwr_on) |=> $stable(cause_q));
  a_r5_halt_off: assert property (@(posedge clk) disable iff (pwr_on)
    (cpu_halt && !halt_en_q && !ext_rst && !clk_lost && !wdog_exp && !sw_rst_stb && !busy)
      |=> $stable(cause_q) && !busy);
  a_r6_keep_en: assert property (@(posedge clk) disable iff (pwr_on)
    (sw_rst_stb && !(wr_en && wr_addr == A_CTRL)) |=> $stable(halt_en_q));
  a_r7_hold_rst: assert property (@(posedge clk) disable iff (pwr_on)
    any_req |=> sys_rst);
  a_r8_ro: assert property (@(posedge clk) disable iff (pwr_on)
    (wr_en && wr_addr == A_CAUSE && !any_req) |=> $stable(cause_q));
endmodule

// File: tb/tb_rst_cause_ctl.sv
`timescale 1ns/1ps
module tb_rst_cause_ctl;
  logic clk = 1'b0;
  logic pwr_on = 1'b1, ext_rst = 1'b0, clk_lost = 1'b0, wdog_exp = 1'b0, cpu_halt = 1'b0, sw_rst_stb = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic sys_rst;

  always #2.5 clk = ~clk;

  rst_cause_ctl dut (.clk(clk), .pwr_on(pwr_on), .ext_rst(ext_rst), .clk_lost(clk_lost),
    .wdog_exp(wdog_exp), .cpu_halt(cpu_halt), .sw_rst_stb(sw_rst_stb), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sys_rst(sys_rst));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0] m_cause = 6'h01;
  logic m_en = 1'b1;
  int m_cnt = 16;
  logic last_rst;

  function automatic logic [5:0] lowest(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 6'(1 << i);
    return 6'h0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    if (a == 2'd0) return {2'b00, m_cause};
    if (a == 2'd1) return {7'b0, m_en};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // r: {sw, halt, wdog, clk_lost, ext, pwr}
  task automatic cyc(input logic [5:0] r, input logic we, input logic [1:0] wa,
                     input logic [7:0] wd, input logic [1:0] ra, input int expv = -1, input string tag = "");
    logic [5:0] gr;
    @(negedge clk);
    pwr_on = r[0]; ext_rst = r[1]; clk_lost = r[2]; wdog_exp = r[3]; cpu_halt = r[4]; sw_rst_stb = r[5];
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    #1;
    gr = r & {1'b1, m_en, 4'hF};
    last_rst = sys_rst;
    chk("R7 sys_rst", int'(sys_rst), int'((|gr) || m_cnt != 0));
    chk(ra == 2'd0 ? "R1 cause read" : "R9 reg read", int'(rd_data), int'(exp_rd(ra)));
    if (expv >= 0) chk(tag, int'(rd_data), expv);
    @(posedge clk);
    if (r[0]) begin
      m_cause = 6'h01; m_en = 1'b1; m_cnt = 16;
    end else begin
      if (|gr) begin
        if (m_cnt == 0) m_cause = lowest(gr);
        m_cnt = 16;
      end else if (m_cnt > 0) m_cnt--;
      if (we && wa == 2'd1) m_en = wd[0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'(i % 4));
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rc;
    void'($urandom(32'd7741));
    cyc(6'h01, 1'b0, 2'd0, 8'h00, 2'd0);
    cyc(6'h01, 1'b0, 2'd0, 8'h00, 2'd0);
    idle(20);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h01, "R6 reset cause power-up");
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd1, 8'h01, "R6 reset enable set");

    cyc(6'h3E, 1'b0, 2'd0, 8'h00, 2'd0);
    idle(18);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h02, "R2 ext beats lower");
    cyc(6'h0C, 1'b0, 2'd0, 8'h00, 2'd0);
    idle(18);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h04, "R2 clock loss beats watchdog");

    cyc(6'h02, 1'b0, 2'd0, 8'h00, 2'd0);
    idle(5);
    cyc(6'h08, 1'b0, 2'd0, 8'h00, 2'd0);
    idle(18);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h02, "R3 tail request keeps cause");

    cyc(6'h02, 1'b0, 2'd0, 8'h00, 2'd0);
    cyc(6'h02, 1'b0, 2'd0, 8'h00, 2'd0);
    cyc(6'h02, 1'b0, 2'd0, 8'h00, 2'd0);
    begin
      int hi = 0;
      for (int i = 0; i < 25; i++) begin
        cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd0);
        if (last_rst) hi++;
      end
      chk("R7 stretch length", hi, 16);
    end

    cyc(6'h00, 1'b1, 2'd1, 8'hFE, 2'd1);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd1, 8'h00, "R9 enable cleared");
    cyc(6'h10, 1'b0, 2'd0, 8'h00, 2'd0);
    chk("R5 halt disabled no reset", int'(last_rst), 0);
    cyc(6'h10, 1'b0, 2'd0, 8'h00, 2'd0, 8'h02, "R5 halt disabled cause kept");
    cyc(6'h00, 1'b1, 2'd1, 8'h01, 2'd0);
    cyc(6'h10, 1'b0, 2'd0, 8'h00, 2'd0);
    chk("R4 halt enabled reset", int'(last_rst), 1);
    idle(18);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h10, "R4 halt cause");

    cyc(6'h00, 1'b1, 2'd1, 8'h00, 2'd0);
    cyc(6'h20, 1'b0, 2'd0, 8'h00, 2'd0);
    idle(18);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h20, "R6 software cause");
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd1, 8'h00, "R6 software keeps enable");
    cyc(6'h00, 1'b1, 2'd0, 8'hFF, 2'd0);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h20, "R8 write ignored");
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd3, 8'h00, "R9 unused address");
    cyc(6'h01, 1'b0, 2'd0, 8'h00, 2'd0);
    cyc(6'h00, 1'b0, 2'd0, 8'h00, 2'd1, 8'h01, "R6 power-up restores enable");

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] r = '0;
      rc = int'($urandom_range(0, 99));
      if (rc < 1) r[0] = 1'b1;
      else if (rc < 12) r[$urandom_range(1, 5)] = 1'b1;
      else if (rc < 15) r = 6'($urandom_range(1, 63)) & 6'h3E;
      cyc(r, ($urandom_range(0, 9) == 0), 2'($urandom_range(0, 3)), 8'($urandom),
          2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule